// File: doc/BRIEF.md
# Palette Access Port

This block lets a processor reach a shared store of 16-bit colour entries one byte at a time. There are two ports, one for background palettes and one for object palettes. Each port has a pointer register and a data register. The pointer register holds a byte index and an auto-advance flag. The data register reads or writes the byte that the pointer selects. Object entries sit in the upper half of the shared store and background entries in the lower half.

The processor side is a plain register bus. A one-cycle write strobe carries a 2-bit register select and a byte. Every write is accepted in the cycle it is presented, so there is no back-pressure. Reads have no side effects: `bus_rdata` always shows the register named by `bus_sel`. The data register's read view is a register in its own right. It is reloaded on every clock from the addressed byte, so it lags any pointer change or store write by exactly one clock. Pixel lookup and video timing belong to other blocks.

Top module: `pal_access_port`

## Requirements
- R1: After reset, both pointers are 0 with auto-advance off, and reading either pointer register returns 0x40.
- R2: A write to a pointer register loads its byte index from bits 5:0 and its auto-advance flag from bit 7. Bit 6 of the written byte has no effect.
- R3: Reading a pointer register returns the auto-advance flag in bit 7, a constant 1 in bit 6 and the byte index in bits 5:0.
- R4: A data register read returns, from entry (index >> 1) of the port's half, the low byte when index bit 0 is 0 and the high byte when it is 1.
- R5: Background bytes map to entries 0–31 and object bytes to entries 32–63. A write through one port never changes a byte seen through the other.
- R6: A data register write replaces only the addressed byte lane of its entry. The other lane keeps its value.
- R7: When auto-advance is set, each data register write increments that port's index by one, wrapping from 63 to 0.
- R8: With auto-advance clear, a data write leaves the index unchanged. Reads never change any index.
- R9: The data read view shows the result of a pointer write, a data write or an auto-advance one clock after that write takes effect. In the clock between, it shows the byte that was addressed before.
- R10: `bus_sel` encodes 0 = background pointer, 1 = background data, 2 = object pointer, 3 = object data, and `bus_rdata` shows the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 2 | Register select (see R10) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte of the selected register |

## Verification
The bench uses the default `IDX_W = 6`, which gives 32 entries per port and a 64-byte index space. At that size, filling a whole half through auto-advance takes only 64 writes. This brings the 63-to-0 wrap of R7 within reach. It also lets the bench read back every byte of both halves to show that the two ports are kept apart. The one-clock stale window of R9 is sampled right after an auto-advancing write.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int NUM_PORTS = 2;
  localparam int BYTE_W    = 8;
  localparam int ENTRY_W   = 2 * BYTE_W;

  // bus_sel[1] picks the port, bus_sel[0] picks data over pointer
  typedef enum logic [1:0] {
    SEL_BG_PTR   = 2'd0,
    SEL_BG_DATA  = 2'd1,
    SEL_OBJ_PTR  = 2'd2,
    SEL_OBJ_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pal_index_reg.sv
module pal_index_reg #(
  parameter int IDX_W = 6   // byte index width, at most 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_we,
  input  logic             data_we,
  input  logic [IDX_W-1:0] ptr_val,
  input  logic             inc_val,
  output logic [IDX_W-1:0] idx_q,
  output logic             inc_q,
  output logic [7:0]       ptr_rd
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      inc_q <= 1'b0;
    end else if (ptr_we) begin
      idx_q <= ptr_val;
      inc_q <= inc_val;
    end else if (data_we && inc_q) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  // pointer read: flag on top, filler ones, index at the bottom
  always_comb begin
    ptr_rd             = 8'hFF;
    ptr_rd[IDX_W-1:0]  = idx_q;
    ptr_rd[7]          = inc_q;
  end
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int IDX_W = 6
) (
  input  logic                                    clk,
  input  logic                                    we,
  input  logic                                    we_port,
  input  logic [IDX_W-1:0]                        we_idx,
  input  logic [7:0]                              we_byte,
  input  logic [pal_pkg::NUM_PORTS-1:0][IDX_W-1:0] rd_idx,
  output logic [pal_pkg::NUM_PORTS-1:0][7:0]       rd_byte
);
  import pal_pkg::*;
  localparam int HALF_ENT = 2 ** (IDX_W - 1);
  localparam int ENTRIES  = NUM_PORTS * HALF_ENT;
  localparam int ADDR_W   = $clog2(ENTRIES);

  logic [ENTRY_W-1:0] mem_q [ENTRIES];
  logic [ADDR_W-1:0]  waddr;

  assign waddr = {we_port, we_idx[IDX_W-1:1]};

  // contents are not reset; only the addressed lane is written
  always_ff @(posedge clk) begin
    if (we) begin
      if (we_idx[0]) mem_q[waddr][ENTRY_W-1:BYTE_W] <= we_byte;
      else           mem_q[waddr][BYTE_W-1:0]       <= we_byte;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    logic [ADDR_W-1:0]  raddr;
    logic [ENTRY_W-1:0] rword;
    assign raddr      = {1'(p), rd_idx[p][IDX_W-1:1]};
    assign rword      = mem_q[raddr];
    assign rd_byte[p] = rd_idx[p][0] ? rword[ENTRY_W-1:BYTE_W] : rword[BYTE_W-1:0];
  end
endmodule

// File: rtl/pal_view.sv
module pal_view (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byte_in,
  output logic [7:0] view_q
);
  // reloaded every clock: one clock behind pointer or store changes
  always_ff @(posedge clk) begin
    if (!rst_n) view_q <= '0;
    else        view_q <= byte_in;
  end
endmodule

// File: rtl/pal_access_port.sv
module pal_access_port #(
  parameter int IDX_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  import pal_pkg::*;

  logic [NUM_PORTS-1:0][IDX_W-1:0] port_idx;
  logic [NUM_PORTS-1:0]            port_inc;
  logic [NUM_PORTS-1:0][7:0]       ptr_rd;
  logic [NUM_PORTS-1:0][7:0]       store_byte;
  logic [NUM_PORTS-1:0][7:0]       view;
  logic                            data_wr;

  assign data_wr = bus_wr && bus_sel[0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = (bus_sel[1] == 1'(p));

    pal_index_reg #(.IDX_W(IDX_W)) u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .ptr_we  (bus_wr && hit && !bus_sel[0]),
      .data_we (bus_wr && hit && bus_sel[0]),
      .ptr_val (bus_wdata[IDX_W-1:0]),
      .inc_val (bus_wdata[7]),
      .idx_q   (port_idx[p]),
      .inc_q   (port_inc[p]),
      .ptr_rd  (ptr_rd[p])
    );

    pal_view u_view (
      .clk     (clk),
      .rst_n   (rst_n),
      .byte_in (store_byte[p]),
      .view_q  (view[p])
    );
  end

  pal_store #(.IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .we      (data_wr),
    .we_port (bus_sel[1]),
    .we_idx  (port_idx[bus_sel[1]]),
    .we_byte (bus_wdata),
    .rd_idx  (port_idx),
    .rd_byte (store_byte)
  );

  always_comb begin
    if (bus_sel[0]) bus_rdata = view[bus_sel[1]];
    else            bus_rdata = ptr_rd[bus_sel[1]];
  end
endmodule

// File: rtl/pal_access_port_chk.sv
module pal_access_port_chk #(
  parameter int IDX_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [1:0]             bus_sel,
  input logic [7:0]             bus_wdata,
  input logic [7:0]             bus_rdata,
  input logic [1:0][IDX_W-1:0]  port_idx,
  input logic [1:0]             port_inc
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (port_idx == '0) && (port_inc == '0));

  assert_ptr_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel[0] |-> bus_rdata[6] && (bus_rdata[7] == port_inc[bus_sel[1]]));

  for (genvar p = 0; p < 2; p++) begin : g_chk
    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == {1'(p), 1'b0}) |=>
        (port_idx[p] == $past(bus_wdata[IDX_W-1:0])) && (port_inc[p] == $past(bus_wdata[7])));

    assert_autoinc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == {1'(p), 1'b1} && port_inc[p]) |=>
        (port_idx[p] == IDX_W'($past(port_idx[p]) + IDX_W'(1))));

    assert_idx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr || bus_sel[1] != 1'(p) || (bus_sel[0] && !port_inc[p])) |=>
        $stable(port_idx[p]) && $stable(port_inc[p]));
  end
endmodule

bind pal_access_port pal_access_port_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .port_idx  (port_idx),
  .port_inc  (port_inc)
);

// File: tb/pal_access_port_bench.sv
module pal_access_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model: byte address = port*64 + index
  logic [7:0] mdl [128];
  logic [5:0] midx [2];
  logic       minc [2];

  always #4 clk = ~clk;

  pal_access_port u_pal_access_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (!sel[0]) begin
      midx[sel[1]] = d[5:0]; minc[sel[1]] = d[7];
    end else begin
      mdl[{sel[1], midx[sel[1]]}] = d;
      if (minc[sel[1]]) midx[sel[1]] = midx[sel[1]] + 6'd1;
    end
  endtask

  task automatic rd(logic [1:0] sel, output logic [7:0] v);
    bus_wr = 1'b0; bus_sel = sel;
    @(negedge clk);
    #1 v = bus_rdata;
  endtask

  function automatic logic [7:0] ptr_exp(int p);
    return {minc[p], 1'b1, midx[p]};
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); check("R1 bg pointer", v, 8'h40);
    rd(2'd2, v); check("R1 obj pointer", v, 8'h40);
  endtask

  task automatic t_ptr_fields();
    logic [7:0] v;
    wr(2'd0, 8'hBF); rd(2'd0, v); check("R2 R3 bg ptr 0xBF", v, 8'hFF);
    wr(2'd0, 8'h05); rd(2'd0, v); check("R2 bit6 ignored", v, 8'h45);
    wr(2'd2, 8'h9A); rd(2'd2, v); check("R3 obj ptr", v, 8'hDA);
    rd(2'd0, v); check("R10 bg ptr kept", v, 8'h45);
  endtask

  task automatic t_fill(int p, int seed);
    logic [7:0] v;
    wr({1'(p), 1'b0}, 8'h80);
    for (int i = 0; i < 64; i++) wr({1'(p), 1'b1}, 8'((i * 7 + seed) & 255));
    rd({1'(p), 1'b0}, v); check("R7 wrap to 0", v, 8'hC0);
    for (int i = 0; i < 64; i++) begin
      wr({1'(p), 1'b0}, 8'(i));
      rd({1'(p), 1'b1}, v);
      check(p ? "R5 R4 obj byte" : "R4 bg byte", v, mdl[{1'(p), 6'(i)}]);
    end
  endtask

  task automatic t_isolation();
    logic [7:0] v;
    for (int i = 0; i < 64; i += 9) begin
      wr(2'd0, 8'(i)); rd(2'd1, v); check("R5 bg untouched by obj", v, mdl[{1'b0, 6'(i)}]);
    end
  endtask

  task automatic t_lane();
    logic [7:0] v;
    wr(2'd0, 8'd10); wr(2'd1, 8'hAA);
    rd(2'd1, v); check("R6 written lane", v, 8'hAA);
    repeat (3) rd(2'd1, v);
    rd(2'd0, v); check("R8 no advance", v, 8'h4A);
    wr(2'd0, 8'd11); rd(2'd1, v); check("R6 other lane kept", v, mdl[11]);
    wr(2'd2, 8'd10); rd(2'd3, v); check("R5 obj lane kept", v, mdl[64 + 10]);
  endtask

  task automatic t_view_lag();
    logic [7:0] old20, v;
    old20 = mdl[20];
    wr(2'd0, 8'h94);
    @(negedge clk); bus_sel = 2'd1; bus_wdata = 8'h5C; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    mdl[20] = 8'h5C; midx[0] = 6'd21;
    #1 check("R9 stale view", bus_rdata, old20);
    @(negedge clk); #1 check("R9 view follows", bus_rdata, mdl[21]);
    wr(2'd0, 8'd20); rd(2'd1, v); check("R9 written byte", v, 8'h5C);
    rd(2'd0, v); check("R3 ptr after move", v, ptr_exp(0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    midx[0] = 0; midx[1] = 0; minc[0] = 0; minc[1] = 0;
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ptr_fields();
    t_fill(0, 3);
    t_fill(1, 101);
    t_isolation();
    t_lane();
    t_view_lag();
    finish_run();
  end
endmodule